// File: doc/BRIEF.md
# Four-Channel Event Timer Bank

This block holds four identical down-counting event timers driven by a shared one-microsecond tick strobe. Software programs each timer through one 32-bit control word that carries an enable flag, a mode flag (repeating or single-shot) and a count field. A timer loaded with value N raises its interrupt on the (N+1)-th tick after the write, so an interval of P ticks is programmed as P-1.

Each timer has a level-sensitive, active-high interrupt output that stays set until software writes a one to the pending bit of that timer's status word. In repeating mode the timer reloads and keeps counting after each expiry; in single-shot mode it clears its own enable flag and halts at zero. A simple single-cycle register port gives write access and combinational read access to both words of every timer.

Top module: `evt_timer_bank`

## Requirements
- R1: While `rst` is high and on the cycle after it, every `irq` bit is 0 and every register reads 0.
- R2: Timer k has its control word at byte offset base(k) and its status word at base(k)+4, with bases 0x00, 0x08, 0x50 and 0x58 for k = 0..3; any other address reads 0 and a write to it changes no register and no interrupt.
- R3: Control word: bit 31 = enable, bit 30 = repeating mode (1) or single-shot (0), bits [28:0] = count value; it reads back as written with bit 29 always 0.
- R4: In single-shot mode a timer written with count N and enable 1 sets its `irq` bit on the (N+1)-th tick after the write, its enable bit then reads 0 and its live count stays at 0.
- R5: In repeating mode a timer reloads count N at expiry, keeps its enable bit set, and sets its `irq` bit again every N+1 ticks.
- R6: An `irq` bit stays high until a write to that timer's status word with bit 30 set clears it; a status write with bit 30 clear has no effect.
- R7: When a clear of the pending flag and a new expiry fall in the same cycle, the expiry wins and `irq` stays high.
- R8: Writing 0 to a control word stops that timer: later ticks raise no interrupt and its count stays unchanged.
- R9: The status word returns the pending flag in bit 30 and the live down-count in bits [28:0], all other bits 0.
- R10: The count moves only on cycles with `tick` high; a control write in the same cycle as a tick loads the written count and the tick has no effect on that timer.
- R11: The four timers are independent: activity on one never changes another's registers or `irq` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe per microsecond |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 4 | Level interrupt, one bit per timer |

## Verification
The bench builds the block with its default parameters: four timers, a 29-bit count field and an 8-bit address, which places all four timer bases including the split pair at 0x50/0x58 in the decoded range. Because the bench drives the tick strobe itself, small count values bring single-shot expiry, repeated reloads and the zero-count case (expiry on every tick) within a few cycles, while the all-ones control write exercises the full count field and the unused bit 29 without counting it down. The clear-versus-expiry collision and the write-versus-tick collision are both driven in a single cycle.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int REG_W    = 32;
    localparam int EN_BIT   = 31;
    localparam int MODE_BIT = 30;
    localparam int PEND_BIT = 30;

    // Per-timer operating flags carried as one unit.
    typedef struct packed {
        logic run;
        logic repeat_mode;
    } tmr_mode_t;

    // Byte offset of timer idx: pairs of timers separated by 0x50.
    function automatic int unsigned tmr_base(input int unsigned idx);
        return (idx / 2) * 32'h50 + (idx % 2) * 32'h8;
    endfunction

endpackage

// File: rtl/evt_timer_dec.sv
module evt_timer_dec
    import evt_timer_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_TMR-1:0] hit_ctrl,
    output logic [NUM_TMR-1:0] hit_stat
);

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(tmr_base(g));
        localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(tmr_base(g) + 4);
        assign hit_ctrl[g] = (addr == CTRL_A);
        assign hit_stat[g] = (addr == STAT_A);
    end

endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ctrl_we,
    input  logic             stat_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] stat_q,
    output logic             irq
);

    tmr_mode_t        mode_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             step;
    logic             expire;
    logic             ack;

    // A register write takes precedence over a tick in the same cycle.
    assign step   = tick && mode_q.run && !ctrl_we;
    assign expire = step && (cnt_q == '0);
    assign ack    = stat_we && wdata[PEND_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            reload_q <= '0;
            cnt_q    <= '0;
        end else if (ctrl_we) begin
            mode_q.run         <= wdata[EN_BIT];
            mode_q.repeat_mode <= wdata[MODE_BIT];
            reload_q           <= wdata[CNT_W-1:0];
            cnt_q              <= wdata[CNT_W-1:0];
        end else if (expire) begin
            if (mode_q.repeat_mode) begin
                cnt_q <= reload_q;
            end else begin
                mode_q.run <= 1'b0;
            end
        end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (expire) begin
            pend_q <= 1'b1;
        end else if (ack) begin
            pend_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_q           = REG_W'(reload_q);
        ctrl_q[EN_BIT]   = mode_q.run;
        ctrl_q[MODE_BIT] = mode_q.repeat_mode;
        stat_q           = REG_W'(cnt_q);
        stat_q[PEND_BIT] = pend_q;
    end

    assign irq = pend_q;

endmodule

// File: rtl/evt_timer_bank.sv
module evt_timer_bank
    import evt_timer_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 29,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic [NUM_TMR-1:0] irq
);

    logic [NUM_TMR-1:0] hit_ctrl;
    logic [NUM_TMR-1:0] hit_stat;
    logic [REG_W-1:0]   ctrl_q [NUM_TMR];
    logic [REG_W-1:0]   stat_q [NUM_TMR];

    evt_timer_dec #(
        .NUM_TMR (NUM_TMR),
        .ADDR_W  (ADDR_W)
    ) u_dec (
        .addr     (addr),
        .hit_ctrl (hit_ctrl),
        .hit_stat (hit_stat)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        evt_timer_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .ctrl_we (wr_en && hit_ctrl[g]),
            .stat_we (wr_en && hit_stat[g]),
            .wdata   (wdata),
            .ctrl_q  (ctrl_q[g]),
            .stat_q  (stat_q[g]),
            .irq     (irq[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (hit_ctrl[i]) rdata = rdata | ctrl_q[i];
            if (hit_stat[i]) rdata = rdata | stat_q[i];
        end
    end

endmodule

// File: rtl/evt_timer_bank_chk.sv
module evt_timer_bank_chk
    import evt_timer_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 29,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [REG_W-1:0]   wdata,
    input logic [NUM_TMR-1:0] irq
);

    // R1: interrupts are low on the cycle after reset is seen.
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (irq == '0))
        else $error("p_reset_quiet_r1");

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(tmr_base(g));
        localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(tmr_base(g) + 4);

        // R6: a raised interrupt holds unless its own clear is written.
        p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
            irq[g] && !(wr_en && addr == STAT_A && wdata[PEND_BIT]) |=> irq[g])
            else $error("p_irq_hold_r6");

        // R6: a clear without a tick always drops the interrupt.
        p_irq_clear_r6: assert property (@(posedge clk) disable iff (rst)
            wr_en && addr == STAT_A && wdata[PEND_BIT] && !tick |=> !irq[g])
            else $error("p_irq_clear_r6");

        // R10: a new expiry can only occur on a tick cycle.
        p_tick_only_r10: assert property (@(posedge clk) disable iff (rst)
            !irq[g] && !tick |=> !irq[g])
            else $error("p_tick_only_r10");

        // R8: writing zero to the control word raises nothing that cycle.
        p_stop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
            wr_en && addr == CTRL_A && wdata == '0 && !irq[g] |=> !irq[g])
            else $error("p_stop_quiet_r8");
    end

endmodule

bind evt_timer_bank evt_timer_bank_chk #(
    .NUM_TMR (NUM_TMR),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .irq   (irq)
);

// File: tb/evt_timer_bank_tb.sv
module evt_timer_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] BASE [4] = '{8'h00, 8'h08, 8'h50, 8'h58};

    always #10 clk = ~clk;

    evt_timer_bank u_dut (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, applied at the falling edge.
    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 32'h0, 1'b1);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq after reset", 32'(irq), 32'h0);
        for (int k = 0; k < 4; k++) begin
            rd(BASE[k], d);     chk("R1 ctrl after reset", d, 32'h0);
            rd(BASE[k] + 4, d); chk("R1 status after reset", d, 32'h0);
        end
    endtask

    task automatic t_map;
        logic [31:0] d;
        for (int k = 0; k < 4; k++) wr(BASE[k], 32'h10 + k);
        for (int k = 0; k < 4; k++) begin
            rd(BASE[k], d);     chk("R2 ctrl at base", d, 32'h10 + k);
            rd(BASE[k] + 4, d); chk("R2 status at base+4", d, 32'h10 + k);
        end
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d);  chk("R2 unmapped reads zero", d, 32'h0);
        rd(BASE[0], d); chk("R2 unmapped write ignored", d, 32'h10);
        chk("R2 unmapped write no irq", 32'(irq), 32'h0);
    endtask

    task automatic t_fields;
        logic [31:0] d;
        wr(BASE[1], 32'hFFFF_FFFF);
        rd(BASE[1], d);     chk("R3 ctrl readback bit29 zero", d, 32'hDFFF_FFFF);
        rd(BASE[1] + 4, d); chk("R9 full count in status", d, 32'h1FFF_FFFF);
        for (int k = 0; k < 4; k++) wr(BASE[k], 32'h0);
    endtask

    task automatic t_oneshot;
        logic [31:0] d;
        wr(BASE[1], 32'h8000_0003);
        ticks(1);
        rd(BASE[1] + 4, d); chk("R9 live count", d, 32'h2);
        ticks(2);
        chk("R4 no irq before N+1 ticks", 32'(irq), 32'h0);
        ticks(1);
        chk("R4 irq on tick N+1", 32'(irq), 32'h2);
        rd(BASE[1], d);     chk("R4 enable self-clears", d, 32'h3);
        rd(BASE[1] + 4, d); chk("R9 pending flag", d, 32'h4000_0000);
        ticks(2);
        rd(BASE[1] + 4, d); chk("R4 count stays zero", d, 32'h4000_0000);
        wr(BASE[1] + 4, 32'hBFFF_FFFF);
        chk("R6 clear with bit30 low ignored", 32'(irq), 32'h2);
        wr(BASE[1] + 4, 32'h4000_0000);
        chk("R6 clear drops irq", 32'(irq), 32'h0);
    endtask

    task automatic t_periodic;
        logic [31:0] d;
        wr(BASE[2], 32'hC000_0001);
        ticks(1);
        chk("R5 no irq after one tick", 32'(irq), 32'h0);
        ticks(1);
        chk("R5 first expiry, R11 others quiet", 32'(irq), 32'h4);
        wr(BASE[2] + 4, 32'h4000_0000);
        ticks(1);
        chk("R5 quiet between periods", 32'(irq), 32'h0);
        ticks(1);
        chk("R5 second expiry", 32'(irq), 32'h4);
        rd(BASE[2], d);     chk("R5 enable kept", d, 32'hC000_0001);
        rd(BASE[2] + 4, d); chk("R5 reload in status", d, 32'h4000_0001);
        wr(BASE[2], 32'h0);
        wr(BASE[2] + 4, 32'h4000_0000);
        chk("R11 all clear", 32'(irq), 32'h0);
    endtask

    task automatic t_race;
        wr(BASE[3], 32'hC000_0000);
        ticks(1);
        chk("R5 zero count expires each tick", 32'(irq), 32'h8);
        cyc(1'b1, BASE[3] + 4, 32'h4000_0000, 1'b1);
        chk("R7 expiry beats clear", 32'(irq), 32'h8);
        wr(BASE[3], 32'h0);
        wr(BASE[3] + 4, 32'h4000_0000);
        chk("R7 plain clear after race", 32'(irq), 32'h0);
    endtask

    task automatic t_stop;
        logic [31:0] d;
        wr(BASE[0], 32'h8000_0002);
        ticks(1);
        wr(BASE[0], 32'h0);
        ticks(5);
        chk("R8 stopped timer silent", 32'(irq), 32'h0);
        rd(BASE[0] + 4, d); chk("R8 count frozen", d, 32'h0);
    endtask

    task automatic t_tick_write;
        logic [31:0] d;
        cyc(1'b1, BASE[0], 32'h8000_0002, 1'b1);
        rd(BASE[0] + 4, d); chk("R10 write wins over tick", d, 32'h2);
        repeat (3) @(negedge clk);
        rd(BASE[0] + 4, d); chk("R10 no count without tick", d, 32'h2);
        wr(BASE[0], 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_fields();
        t_oneshot();
        t_periodic();
        t_race();
        t_stop();
        t_tick_write();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule